// File: doc/BRIEF.md
# Block-ID Trace Table with Next-Trace Predictor

This block keeps short traces as lists of basic-block identifiers rather than as instructions. It also predicts which trace comes next. On the fetch side, a lookup gives the identifier of the block fetched last. The table hashes that identifier with a global branch history register. One cycle later it answers with up to four block identifiers, a per-slot valid flag and per-slot collapse steering bits. These drive the replicated block-cache copies and the final collapse multiplexer. A miss raises no hit and returns all slots empty, and fetch then falls back to the normal instruction path.

On the completion side, a finished trace is written back. The write carries its own last-block identifier and the history snapshot that was live when the trace was predicted. When the addressed entry already holds exactly the same trace, the write is dropped so that array write bandwidth is not spent on it. A one-cycle flag reports this. Branch outcomes are shifted into the history register as they resolve.

Top module: `trace_table`

## Requirements
- R1: After reset every entry is invalid, `ghist` is zero and all prediction outputs and `wr_dup` are zero; the first lookups after reset miss.
- R2: The entry index is the low log2(ENTRIES) bits of (history XOR zero-extended block id), and the stored tag is the full block id; with defaults, id 63 under history 255 addresses entry 192.
- R3: One cycle after a lookup (`lk_valid`=1), `pred_valid` is 1. If the indexed entry is valid and its tag equals `lk_last_bid`, then `pred_hit` is 1 and the stored slot valids, ids and steering appear. Slot i occupies `pred_bids[i*BID_W +: BID_W]` and `pred_steer[i*STEER_W +: STEER_W]`.
- R4: On a miss, `pred_valid` is 1 while `pred_hit`, `pred_slot_vld`, `pred_bids` and `pred_steer` are all zero. With no lookup, all prediction outputs are zero.
- R5: When `br_valid` is 1, `ghist` shifts left by one on the next edge and takes `br_taken` into bit 0. Otherwise `ghist` holds.
- R6: A completion write (`wr_valid`=1) indexed by `wr_last_bid` and `wr_hist` stores the tag and trace, replacing any previous content. Lookups made from the next cycle on see it.
- R7: A write whose tag, slot valids, ids and steering equal a valid entry is not performed, and `wr_dup` is 1 in the following cycle. In every other case `wr_dup` is 0.
- R8: When a lookup and a write address the same entry in the same cycle, the lookup returns the contents from before the write.
- R9: A lookup in the same cycle as a history shift uses the history from before the shift.
- R10: A lookup that reaches a valid entry holding a different tag is a miss.
- R11: Ids and steering of slots written with valid=0 are stored and returned as zero. Two traces that differ only in unused slots therefore count as identical for R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch outcome is presented |
| br_taken | input | 1 | Outcome bit shifted into history |
| ghist | output | HIST_W | Global branch history register |
| lk_valid | input | 1 | Fetch-side lookup request |
| lk_last_bid | input | BID_W | Id of the block fetched last |
| pred_valid | output | 1 | Answer to the lookup of the previous cycle |
| pred_hit | output | 1 | Predicted trace found |
| pred_slot_vld | output | SLOTS | Valid flag per slot |
| pred_bids | output | SLOTS*BID_W | Block ids, slot i at i*BID_W |
| pred_steer | output | SLOTS*STEER_W | Collapse steering, slot i at i*STEER_W |
| wr_valid | input | 1 | Completion-side write |
| wr_last_bid | input | BID_W | Block id that keys the written trace |
| wr_hist | input | HIST_W | History snapshot that keys the written trace |
| wr_slot_vld | input | SLOTS | Slot valids of the completed trace |
| wr_bids | input | SLOTS*BID_W | Block ids of the completed trace |
| wr_steer | input | SLOTS*STEER_W | Steering bits of the completed trace |
| wr_dup | output | 1 | The previous cycle's write was dropped as identical |

## Verification
Two functions can meet in one cycle: a fetch lookup with a completion write to the same entry, and a fetch lookup with a history shift. The bench provokes the first by issuing a lookup and an overwrite with a new tag to one index together. It expects the old miss, and then a hit on the lookup that follows. It provokes the second by looking up while shifting a branch outcome in. It judges that case against an index built from the history before the shift.

// File: rtl/trace_table.sv
module trace_table #(
  parameter int SLOTS   = 4,
  parameter int BID_W   = 6,
  parameter int HIST_W  = 8,
  parameter int ENTRIES = 256,
  parameter int STEER_W = 2
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       br_valid,
  input  logic                       br_taken,
  output logic [HIST_W-1:0]          ghist,
  input  logic                       lk_valid,
  input  logic [BID_W-1:0]           lk_last_bid,
  output logic                       pred_valid,
  output logic                       pred_hit,
  output logic [SLOTS-1:0]           pred_slot_vld,
  output logic [SLOTS*BID_W-1:0]     pred_bids,
  output logic [SLOTS*STEER_W-1:0]   pred_steer,
  input  logic                       wr_valid,
  input  logic [BID_W-1:0]           wr_last_bid,
  input  logic [HIST_W-1:0]          wr_hist,
  input  logic [SLOTS-1:0]           wr_slot_vld,
  input  logic [SLOTS*BID_W-1:0]     wr_bids,
  input  logic [SLOTS*STEER_W-1:0]   wr_steer,
  output logic                       wr_dup
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PAY_W = SLOTS * (1 + BID_W + STEER_W);

  logic [ENTRIES-1:0] ent_vld;
  logic [BID_W-1:0]   tag_mem [ENTRIES];
  logic [PAY_W-1:0]   pay_mem [ENTRIES];
  logic [PAY_W-1:0]   pred_pay;

  function automatic logic [IDX_W-1:0] hash(input logic [BID_W-1:0] b,
                                            input logic [HIST_W-1:0] h);
    return IDX_W'(h) ^ IDX_W'(b);
  endfunction

  wire [IDX_W-1:0] lk_idx = hash(lk_last_bid, ghist);
  wire [IDX_W-1:0] wr_idx = hash(wr_last_bid, wr_hist);

  logic [SLOTS*BID_W-1:0]   wr_bids_m;
  logic [SLOTS*STEER_W-1:0] wr_steer_m;
  for (genvar s = 0; s < SLOTS; s++) begin : g_mask
    assign wr_bids_m[s*BID_W +: BID_W]      = wr_slot_vld[s] ? wr_bids[s*BID_W +: BID_W] : '0;
    assign wr_steer_m[s*STEER_W +: STEER_W] = wr_slot_vld[s] ? wr_steer[s*STEER_W +: STEER_W] : '0;
  end

  wire [PAY_W-1:0] wr_pay = {wr_slot_vld, wr_bids_m, wr_steer_m};
  wire same   = ent_vld[wr_idx] && (tag_mem[wr_idx] == wr_last_bid) && (pay_mem[wr_idx] == wr_pay);
  wire do_wr  = wr_valid && !same;
  wire lk_hit = lk_valid && ent_vld[lk_idx] && (tag_mem[lk_idx] == lk_last_bid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld    <= '0;
      ghist      <= '0;
      pred_valid <= 1'b0;
      pred_hit   <= 1'b0;
      pred_pay   <= '0;
      wr_dup     <= 1'b0;
    end else begin
      if (br_valid) ghist <= {ghist[HIST_W-2:0], br_taken};
      if (do_wr) ent_vld[wr_idx] <= 1'b1;
      pred_valid <= lk_valid;
      pred_hit   <= lk_hit;
      pred_pay   <= lk_hit ? pay_mem[lk_idx] : '0;
      wr_dup     <= wr_valid && same;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      tag_mem[wr_idx] <= wr_last_bid;
      pay_mem[wr_idx] <= wr_pay;
    end
  end

  assign {pred_slot_vld, pred_bids, pred_steer} = pred_pay;

  logic slot_junk;
  always_comb begin
    slot_junk = 1'b0;
    for (int s = 0; s < SLOTS; s++)
      if (!pred_slot_vld[s] && (pred_bids[s*BID_W +: BID_W] != '0 ||
                                pred_steer[s*STEER_W +: STEER_W] != '0))
        slot_junk = 1'b1;
  end

  assert_empty_slot_zero_R11: assert property (@(posedge clk) disable iff (!rst_n) !slot_junk);
  assert_miss_no_slots_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (pred_slot_vld == '0));
  assert_pred_follows_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);
  assert_no_pred_unasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!pred_valid && !pred_hit));
  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (ghist == {$past(ghist[HIST_W-2:0]), $past(br_taken)}));
  assert_hist_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(ghist));
  assert_dup_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !wr_dup);
endmodule

// File: tb/trace_table_tb.sv
module trace_table_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_valid = 0, br_taken = 0, lk_valid = 0, wr_valid = 0;
  logic [5:0] lk_last_bid = '0, wr_last_bid = '0;
  logic [7:0] wr_hist = '0, wr_steer = '0;
  logic [3:0] wr_slot_vld = '0;
  logic [23:0] wr_bids = '0;
  logic [7:0] ghist;
  logic pred_valid, pred_hit, wr_dup;
  logic [3:0] pred_slot_vld;
  logic [23:0] pred_bids;
  logic [7:0] pred_steer;

  always #10 clk = ~clk;

  trace_table u_dut (.*);

  typedef struct packed {
    bit lk; bit hit; bit [3:0] sv; bit [23:0] bd; bit [7:0] st; bit dup; bit [7:0] hist;
  } exp_t;
  exp_t q[$];
  string tq[$];

  int checks = 0, errors = 0;
  bit       mv   [256];
  bit [5:0] mtag [256];
  bit [3:0] msv  [256];
  bit [23:0] mbd [256];
  bit [7:0] mst  [256];
  bit [7:0] mh = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  initial forever begin
    exp_t e; string t;
    @(posedge clk); #2;
    if (q.size() > 0) begin
      e = q.pop_front(); t = tq.pop_front();
      chk(pred_valid == e.lk, t, "pred_valid", pred_valid, e.lk);
      chk(pred_hit == e.hit, t, "pred_hit", pred_hit, e.hit);
      chk({pred_slot_vld, pred_bids, pred_steer} == {e.sv, e.bd, e.st}, t, "trace",
          {pred_slot_vld, pred_bids, pred_steer}, {e.sv, e.bd, e.st});
      chk(wr_dup == e.dup, t, "wr_dup", wr_dup, e.dup);
      chk(ghist == e.hist, t, "ghist", ghist, e.hist);
    end
  end

  task automatic step(input bit lv, input bit [5:0] lb, input bit bv, input bit bt,
                      input bit wv, input bit [5:0] wb, input bit [7:0] wh,
                      input bit [3:0] sv, input bit [23:0] bd, input bit [7:0] st,
                      input string tag);
    exp_t e;
    bit [7:0] li, wi;
    bit [23:0] bdm;
    bit [7:0] stm;
    @(negedge clk);
    lk_valid = lv; lk_last_bid = lb; br_valid = bv; br_taken = bt;
    wr_valid = wv; wr_last_bid = wb; wr_hist = wh; wr_slot_vld = sv;
    wr_bids = bd; wr_steer = st;
    e = '0;
    e.lk = lv;
    li = mh ^ {2'b00, lb};
    if (lv && mv[li] && mtag[li] == lb) begin
      e.hit = 1; e.sv = msv[li]; e.bd = mbd[li]; e.st = mst[li];
    end
    bdm = '0; stm = '0;
    for (int i = 0; i < 4; i++) if (sv[i]) begin
      bdm[i*6 +: 6] = bd[i*6 +: 6];
      stm[i*2 +: 2] = st[i*2 +: 2];
    end
    wi = wh ^ {2'b00, wb};
    e.dup = wv && mv[wi] && mtag[wi] == wb && msv[wi] == sv && mbd[wi] == bdm && mst[wi] == stm;
    if (wv && !e.dup) begin
      mv[wi] = 1; mtag[wi] = wb; msv[wi] = sv; mbd[wi] = bdm; mst[wi] = stm;
    end
    if (bv) mh = {mh[6:0], bt};
    e.hist = mh;
    q.push_back(e); tq.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic lookup(input bit [5:0] b, input string tag);
    step(1, b, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic branch(input bit t, input string tag);
    step(0, 0, 1, t, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic write(input bit [5:0] wb, input bit [7:0] wh, input bit [3:0] sv,
                       input bit [23:0] bd, input bit [7:0] st, input string tag);
    step(0, 0, 0, 0, 1, wb, wh, sv, bd, st, tag);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ghist == 0, "R1", "ghist at reset", ghist, 0);
    chk({pred_valid, pred_hit, pred_slot_vld, pred_bids, pred_steer, wr_dup} == '0, "R1",
        "outputs at reset", {pred_valid, pred_hit, pred_slot_vld, pred_bids, pred_steer}, 0);
    rst_n = 1'b1;
    lookup(6'd5, "R1");
    lookup(6'd0, "R4");
    idle("R4");
    step(1, 6'd3, 1, 1, 0, 0, 0, 0, 0, 0, "R9");
    branch(0, "R5");
    branch(1, "R5");
    write(6'd3, 8'd5, 4'b0111, {6'h3F, 6'd9, 6'd8, 6'd7}, 8'b11_10_01_00, "R6");
    lookup(6'd3, "R3");
    lookup(6'd3, "R11");
    write(6'd3, 8'd5, 4'b0111, {6'h3F, 6'd9, 6'd8, 6'd7}, 8'b11_10_01_00, "R7");
    write(6'd3, 8'd5, 4'b0111, {6'h15, 6'd9, 6'd8, 6'd7}, 8'b01_10_01_00, "R7");
    write(6'd3, 8'd5, 4'b0111, {6'h00, 6'd9, 6'd8, 6'd7}, 8'b00_10_01_11, "R7");
    lookup(6'd3, "R6");
    branch(0, "R5");
    lookup(6'd12, "R10");
    step(1, 6'd12, 0, 0, 1, 6'd12, 8'd10, 4'b1111, {6'd40, 6'd41, 6'd42, 6'd43}, 8'hB4, "R8");
    lookup(6'd12, "R8");
    step(1, 6'd12, 1, 1, 0, 0, 0, 0, 0, 0, "R9");
    lookup(6'd12, "R9");
    write(6'd63, 8'd255, 4'b0001, {18'd0, 6'd33}, 8'h02, "R2");
    for (int i = 0; i < 8; i++) branch(1, "R5");
    lookup(6'd63, "R2");
    lookup(6'd62, "R2");
    write(6'd63, 8'd255, 4'b0001, {18'd0, 6'd33}, 8'h02, "R7");
    idle("R4");
    idle("R4");
    @(negedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule